// File: doc/BRIEF.md
# Banked register file addressing unit

This block is the data-memory front end of a small 8-bit controller core. Each cycle it takes one operation on one register and resolves which physical storage location the operation reaches. The register operand is a 5-bit direct address. A file select register (FSR) held inside the block supplies two things: the bank for the upper half of the direct window, and the complete target address when the operand names the indirect slot.

The FSR is visible as an ordinary register at operand 04h. It can be read, written, bit-modified and stepped, just like storage. A bank operation reloads only the three bank bits of the FSR. Every operation's outcome appears on the read-data, zero and skip outputs one clock after the operation is presented. The core uses these to take branches and skip instructions.

Top module: `rfb_front`

## Requirements
- R1: While reset is held and in the cycle after it is released, `rd_data_o`, `zero_o` and `skip_o` are 0, and the FSR reads as 00h.
- R2: Direct operands 01h–0Fh, other than 04h, address one set of shared registers that is the same for every bank setting.
- R3: A direct operand in 10h–1Fh reaches offset operand[3:0] inside the bank given by FSR[7:5]. Each of the eight banks keeps its own contents.
- R4: Operand 00h is the indirect slot and targets the full FSR value. With FSR[4] set, this is banked location FSR[7:5]/FSR[3:0]. With FSR[4] clear, it is the shared register FSR[3:0], and 04h there means the FSR itself.
- R5: Operand 04h reads and writes the FSR. Writing 00h clears it.
- R6: Op code 8 (bank) loads FSR[7:5] from `wdata_i[2:0]` in one cycle and leaves FSR[4:0] unchanged. `rd_data_o` then shows the new FSR.
- R7: Op 3 (set) and op 4 (clear) change only bit `bit_i` of the target, write it back, and show the new value on `rd_data_o`.
- R8: Op 5 (test) shows the target's value on `rd_data_o`, sets `zero_o` to 1 exactly when bit `bit_i` is 0, leaves the target unchanged and gives no skip.
- R9: Op 6 (increment) and op 7 (decrement) write back the result modulo 256 and show it on `rd_data_o`. When the result is 00h they raise both `zero_o` and `skip_o`, including the wrap from FFh to 00h.
- R10: An indirect access whose resolved address is the indirect slot itself (FSR[4] clear, FSR[3:0] = 0) reads 00h, and any write it makes is dropped.
- R11: Reset clears the FSR but leaves both shared and banked register contents unchanged.
- R12: Results appear in the cycle after the operation. `skip_o` lasts one cycle and is 0 after every op other than 6 and 7. Op 0 (no-op), op 1 (read), op 2 (write) and codes 9–15 (treated as no-op) never change `zero_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| op_i | input | 4 | Operation: 0 no-op, 1 read, 2 write, 3 set bit, 4 clear bit, 5 test bit, 6 increment, 7 decrement, 8 bank |
| opnd_i | input | 5 | Direct register operand |
| wdata_i | input | 8 | Write value; bits 2:0 carry the bank for op 8 |
| bit_i | input | 3 | Bit index for ops 3–5 |
| rd_data_o | output | 8 | Value read or result written by the last operation |
| zero_o | output | 1 | Zero flag from the last step or test |
| skip_o | output | 1 | One-cycle skip request after a step that reached 00h |

## Verification
The bench writes a distinct value at the same offset in all eight banks and reads each one back. A design that ignores the bank bits, or decodes them from the wrong FSR field, returns one bank's value for all of them. It runs a full indirect sweep in which the FSR itself serves as the loop counter. The sweep ends when the FSR wraps from FFh to 00h, so a missed wrap skip hangs the loop or leaves banks unfilled. It points the FSR at the indirect slot and at its own address: a design that writes through a null target corrupts a shared register, and one that misroutes 04h loses the FSR read. Reset is pulsed part-way through, and stored values must survive it.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_READ  = 4'd1,
        OP_WRITE = 4'd2,
        OP_BSET  = 4'd3,
        OP_BCLR  = 4'd4,
        OP_BTEST = 4'd5,
        OP_INCSZ = 4'd6,
        OP_DECSZ = 4'd7,
        OP_BANK  = 4'd8
    } rfb_op_e;

    typedef enum logic [1:0] {
        TGT_MEM  = 2'd0,
        TGT_FSR  = 2'd1,
        TGT_NULL = 2'd2
    } rfb_tgt_e;

    localparam int unsigned SLOT_INDIRECT = 0;
    localparam int unsigned SLOT_FSR      = 4;

endpackage

// File: rtl/rfb_map.sv
module rfb_map
    import rfb_pkg::*;
#(
    parameter int unsigned BANK_W = 3,
    parameter int unsigned OFF_W  = 4,
    localparam int unsigned FSR_W = BANK_W + 1 + OFF_W,
    localparam int unsigned WIN   = 2 ** OFF_W,
    localparam int unsigned DEPTH = WIN * (1 + 2 ** BANK_W),
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [OFF_W:0]     opnd_i,
    input  logic [FSR_W-1:0]   fsr_i,
    output rfb_tgt_e           tgt_o,
    output logic [IDX_W-1:0]   idx_o
);

    logic [FSR_W-1:0] eff;

    // Resolve the operand into a full logical address
    always_comb begin
        if (opnd_i == '0) begin
            eff = fsr_i;
        end else if (opnd_i[OFF_W]) begin
            eff = {fsr_i[FSR_W-1 -: BANK_W], opnd_i};
        end else begin
            eff = {{BANK_W{1'b0}}, opnd_i};
        end
    end

    // Banked half lands above the shared window; low half is shared
    always_comb begin
        tgt_o = TGT_MEM;
        idx_o = '0;
        if (eff[OFF_W]) begin
            idx_o = IDX_W'(WIN) + IDX_W'({eff[FSR_W-1 -: BANK_W], eff[OFF_W-1:0]});
        end else if (eff[OFF_W-1:0] == OFF_W'(SLOT_INDIRECT)) begin
            tgt_o = TGT_NULL;
        end else if (eff[OFF_W-1:0] == OFF_W'(SLOT_FSR)) begin
            tgt_o = TGT_FSR;
        end else begin
            idx_o = IDX_W'(eff[OFF_W-1:0]);
        end
    end

endmodule

// File: rtl/rfb_store.sv
module rfb_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 144,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Contents have no reset: they survive a core reset
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/rfb_alu.sv
module rfb_alu
    import rfb_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned BIT_W = $clog2(DATA_W)
) (
    input  rfb_op_e           op_i,
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BIT_W-1:0]  bit_i,
    output logic [DATA_W-1:0] res_o,
    output logic              store_o,
    output logic              step_o,
    output logic              bit_clear_o
);

    logic [DATA_W-1:0] mask;

    always_comb begin
        mask        = DATA_W'(1) << bit_i;
        res_o       = old_i;
        store_o     = 1'b0;
        step_o      = 1'b0;
        bit_clear_o = ~old_i[bit_i];
        unique case (op_i)
            OP_WRITE: begin res_o = wdata_i;        store_o = 1'b1; end
            OP_BSET:  begin res_o = old_i | mask;   store_o = 1'b1; end
            OP_BCLR:  begin res_o = old_i & ~mask;  store_o = 1'b1; end
            OP_INCSZ: begin res_o = old_i + 1'b1;   store_o = 1'b1; step_o = 1'b1; end
            OP_DECSZ: begin res_o = old_i - 1'b1;   store_o = 1'b1; step_o = 1'b1; end
            default:  ;
        endcase
    end

    always_comb begin
        if (op_i == OP_BSET || op_i == OP_BCLR) begin
            AST_BITOP_ONE_BIT: assert (((res_o ^ old_i) & ~(DATA_W'(1) << bit_i)) == '0); // R7
        end
    end

endmodule

// File: rtl/rfb_front.sv
module rfb_front
    import rfb_pkg::*;
#(
    parameter int unsigned BANK_W = 3,
    parameter int unsigned OFF_W  = 4,
    localparam int unsigned FSR_W  = BANK_W + 1 + OFF_W,
    localparam int unsigned DATA_W = FSR_W,
    localparam int unsigned BIT_W  = $clog2(DATA_W),
    localparam int unsigned WIN    = 2 ** OFF_W,
    localparam int unsigned DEPTH  = WIN * (1 + 2 ** BANK_W),
    localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [OFF_W:0]    opnd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BIT_W-1:0]  bit_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              zero_o,
    output logic              skip_o
);

    typedef struct packed {
        logic [FSR_W-1:0]  fsr;
        logic [DATA_W-1:0] rd;
        logic              zero;
        logic              skip;
    } state_t;

    state_t st_d, st_q;

    rfb_op_e           op;
    rfb_tgt_e          tgt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mem_rd, old, res;
    logic              mem_we, store, step, bit_clear;

    assign op = rfb_op_e'(op_i);

    rfb_map #(.BANK_W(BANK_W), .OFF_W(OFF_W)) u_map (
        .opnd_i (opnd_i),
        .fsr_i  (st_q.fsr),
        .tgt_o  (tgt),
        .idx_o  (idx)
    );

    rfb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .we_i    (mem_we),
        .idx_i   (idx),
        .wdata_i (res),
        .rdata_o (mem_rd)
    );

    rfb_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i        (op),
        .old_i       (old),
        .wdata_i     (wdata_i),
        .bit_i       (bit_i),
        .res_o       (res),
        .store_o     (store),
        .step_o      (step),
        .bit_clear_o (bit_clear)
    );

    always_comb begin
        unique case (tgt)
            TGT_MEM: old = mem_rd;
            TGT_FSR: old = st_q.fsr;
            default: old = '0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.skip = 1'b0;
        mem_we    = 1'b0;
        case (op)
            OP_BANK: begin
                st_d.fsr[FSR_W-1 -: BANK_W] = wdata_i[BANK_W-1:0];
                st_d.rd = {wdata_i[BANK_W-1:0], st_q.fsr[OFF_W:0]};
            end
            OP_READ: st_d.rd = old;
            OP_BTEST: begin
                st_d.rd   = old;
                st_d.zero = bit_clear;
            end
            OP_WRITE, OP_BSET, OP_BCLR, OP_INCSZ, OP_DECSZ: begin
                st_d.rd = res;
                if (store && tgt == TGT_MEM) mem_we = 1'b1;
                if (store && tgt == TGT_FSR) st_d.fsr = res;
                if (step) begin
                    st_d.zero = (res == '0);
                    st_d.skip = (res == '0);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.fsr  <= '0;
            st_q.rd   <= '0;
            st_q.zero <= 1'b0;
            st_q.skip <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.rd;
    assign zero_o    = st_q.zero;
    assign skip_o    = st_q.skip;

    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    AST_SKIP_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && skip_o) |-> ($past(op_i) == 4'd6 || $past(op_i) == 4'd7)); // R12
    AST_SKIP_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (rd_data_o == '0 && zero_o)); // R9
    AST_BANK_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_i) == 4'd8) |-> (st_q.fsr[OFF_W:0] == $past(st_q.fsr[OFF_W:0]))); // R6
    AST_BANK_HIGH_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_i) == 4'd8) |-> (st_q.fsr[FSR_W-1 -: BANK_W] == $past(wdata_i[BANK_W-1:0]))); // R6
    AST_NULL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_NULL) |-> !mem_we); // R10
    AST_STORE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (idx < IDX_W'(DEPTH))); // R3

endmodule

// File: tb/rfb_front_bench.sv
`timescale 1ns/1ps
module rfb_front_bench;

    localparam int NOP = 0, RD = 1, WR = 2, BSET = 3, BCLR = 4, BTEST = 5,
                   INCSZ = 6, DECSZ = 7, BANK = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [4:0] opnd_i = '0;
    logic [7:0] wdata_i = '0;
    logic [2:0] bit_i = '0;
    logic [7:0] rd_data_o;
    logic       zero_o, skip_o;

    always #4 clk = ~clk;

    rfb_front u_rfb_front (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opnd_i(opnd_i),
        .wdata_i(wdata_i), .bit_i(bit_i),
        .rd_data_o(rd_data_o), .zero_o(zero_o), .skip_o(skip_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference model: flat logical address space
    logic [7:0] m_mem [256];
    logic [7:0] m_fsr, m_rd;
    logic       m_zero, m_skip;

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare(string req);
        check(req, "rd_data", int'(rd_data_o), int'(m_rd));
        check(req, "zero", int'(zero_o), int'(m_zero));
        check(req, "skip", int'(skip_o), int'(m_skip));
    endtask

    function automatic int resolve(logic [4:0] a);
        logic [7:0] e;
        if (a == 5'd0)  e = m_fsr;
        else if (a[4])  e = {m_fsr[7:5], a};
        else            e = {3'b000, a};
        if (!e[4]) e = e & 8'h0F;
        return int'(e);
    endfunction

    function automatic void model_reset();
        m_fsr = 8'h00; m_rd = 8'h00; m_zero = 1'b0; m_skip = 1'b0;
    endfunction

    // Called at a falling edge; result compared at the next falling edge
    task automatic do_op(string req, int op, int a, int d, int b);
        int e;
        logic [7:0] old, res;
        op_i = 4'(op); opnd_i = 5'(a); wdata_i = 8'(d); bit_i = 3'(b);
        e   = resolve(5'(a));
        old = (e == 0) ? 8'h00 : (e == 4) ? m_fsr : m_mem[e];
        m_skip = 1'b0;
        case (op)
            BANK: begin m_fsr[7:5] = 3'(d); m_rd = m_fsr; end
            RD:   m_rd = old;
            BTEST: begin m_rd = old; m_zero = !old[b]; end
            WR, BSET, BCLR, INCSZ, DECSZ: begin
                case (op)
                    WR:    res = 8'(d);
                    BSET:  res = old | (8'h01 << b);
                    BCLR:  res = old & ~(8'h01 << b);
                    INCSZ: res = old + 8'h01;
                    default: res = old - 8'h01;
                endcase
                m_rd = res;
                if (e == 4) m_fsr = res;
                else if (e != 0) m_mem[e] = res;
                if (op == INCSZ || op == DECSZ) begin
                    m_zero = (res == 8'h00);
                    m_skip = (res == 8'h00);
                end
            end
            default: ;
        endcase
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1");                       // outputs low during reset
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
        do_op("R1", RD, 4, 0, 0);            // FSR reads 00h

        // R2: shared low registers
        do_op("R2", WR, 5, 8'hA5, 0);
        do_op("R2", BANK, 0, 5, 0);
        do_op("R2", RD, 5, 0, 0);
        do_op("R2", WR, 15, 8'h11, 0);
        do_op("R2", BANK, 0, 1, 0);
        do_op("R2", RD, 15, 0, 0);

        // R3: each bank holds its own value at offset 3
        for (int b = 0; b < 8; b++) begin
            do_op("R3", BANK, 0, b, 0);
            do_op("R3", WR, 5'h13, b * 17 + 3, 0);
        end
        for (int b = 7; b >= 0; b--) begin
            do_op("R6", BANK, 0, b, 0);
            do_op("R3", RD, 5'h13, 0, 0);
        end

        // R4: indirect through full FSR
        do_op("R5", WR, 4, 8'h73, 0);
        do_op("R4", RD, 0, 0, 0);
        do_op("R4", WR, 4, 8'h05, 0);
        do_op("R4", RD, 0, 0, 0);
        do_op("R4", WR, 0, 8'h5A, 0);
        do_op("R4", RD, 5, 0, 0);
        do_op("R4", WR, 4, 8'h04, 0);
        do_op("R4", RD, 0, 0, 0);            // FSR through itself

        // R10: indirect slot through itself
        do_op("R10", WR, 4, 8'h20, 0);
        do_op("R10", RD, 0, 0, 0);
        do_op("R10", WR, 0, 8'h55, 0);
        do_op("R10", RD, 0, 0, 0);
        do_op("R10", RD, 5, 0, 0);

        // R5 / R6
        do_op("R5", WR, 4, 8'h00, 0);
        do_op("R5", RD, 4, 0, 0);
        do_op("R6", WR, 4, 8'h1B, 0);
        do_op("R6", BANK, 0, 6, 0);
        do_op("R6", RD, 4, 0, 0);

        // R7 / R8 on bank 3 offset 3 (36h)
        do_op("R6", BANK, 0, 3, 0);
        do_op("R8", BTEST, 5'h13, 0, 0);
        do_op("R8", BTEST, 5'h13, 0, 1);
        do_op("R12", RD, 5'h13, 0, 0);
        do_op("R7", BSET, 5'h13, 0, 7);
        do_op("R7", BCLR, 5'h13, 0, 2);
        do_op("R8", BTEST, 5'h13, 0, 7);
        do_op("R7", RD, 5'h13, 0, 0);

        // R9: steps and wrap
        do_op("R9", WR, 5'h15, 8'hFF, 0);
        do_op("R9", INCSZ, 5'h15, 0, 0);
        do_op("R12", NOP, 0, 0, 0);
        do_op("R9", INCSZ, 5'h15, 0, 0);
        do_op("R9", WR, 4, 8'h95, 0);
        do_op("R9", WR, 0, 8'h01, 0);
        do_op("R9", DECSZ, 0, 0, 0);
        do_op("R9", DECSZ, 0, 0, 0);
        do_op("R12", 12, 0, 0, 0);           // unused code acts as no-op
        do_op("R12", WR, 5, 8'hA5, 0);

        // R4/R9: indirect sweep of every banked location, FSR as counter
        do_op("R5", WR, 4, 8'h00, 0);
        for (int k = 0; k < 200; k++) begin
            do_op("R4", BSET, 4, 0, 4);
            do_op("R4", WR, 0, 8'h3C, 0);
            do_op("R9", INCSZ, 4, 0, 0);
            if (m_skip) break;
        end
        do_op("R9", RD, 4, 0, 0);
        do_op("R3", BANK, 0, 2, 0);
        do_op("R3", RD, 5'h1F, 0, 0);

        // R11: reset keeps contents
        rst_n = 1'b0; op_i = '0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        compare("R11");
        do_op("R11", RD, 4, 0, 0);
        do_op("R11", RD, 5, 0, 0);
        do_op("R11", RD, 5'h10, 0, 0);
        do_op("R11", RD, 15, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule